// File: doc/BRIEF.md
# Expansion Card Auto-Configuration Responder

This block lets a plug-in card on a 16-bit data, 24-bit address asynchronous bus join a daisy-chained start-up configuration. The card takes part only while its chain input is low. While it is selected and still unconfigured, it answers reads in a fixed 128-byte window at page 0xE8 with identification nibbles on data bits 15:12. Firmware then writes the card's 64 KB page number as two nibbles. Once the card commits that page, it stops answering the window, pulls its chain output low so the next card can be configured, and flags every access to its own page.

Two state machines do the work. The bus tracker has the states BS_IDLE, BS_ADDR and BS_DATA:
- It goes from BS_IDLE to BS_ADDR when a write cycle starts (address strobe low, read line low).
- It goes from BS_ADDR to BS_DATA when a data strobe falls, and latches the data at that point.
- It goes from BS_ADDR back to BS_IDLE if the strobe rises with no data phase.
- It goes from BS_DATA back to BS_IDLE when the strobe rises, and issues a one-cycle write-complete pulse.

The configuration controller has the states CF_UNCONF, CF_PARTIAL and CF_CONF:
- A high-nibble write moves it from CF_UNCONF to CF_PARTIAL. A repeated high-nibble write keeps it in CF_PARTIAL.
- A low-nibble write moves it from either CF_UNCONF or CF_PARTIAL to CF_CONF.
- CF_CONF is left only through bus reset.

Top module: `autocfg_responder`

## Requirements
- R1: While bus reset is low and after it, the chain output is high, board select is low and the read-data enable is low.
- R2: While the chain input is low and the card is unconfigured, a read (read line high, address strobe low) at page 0xE8 offset 4*k, k in 0..11 except 3, returns identification nibble k in data bits 15:12 with bits 11:0 zero, and the read-data enable is high.
- R3: While the chain input is high, reads in the window leave the read-data enable low.
- R4: While the chain input is high, writes to the window do not configure the card: the chain output stays high and the intended page is not selected.
- R5: A write of the high page nibble at offset 0x48 alone does not configure the card: the chain output stays high and identification reads are still answered.
- R6: When the write of the low page nibble at offset 0x4A completes, the card is configured. The chain output goes low and the page becomes {nibble@0x48, nibble@0x4A}, each nibble taken from data bits 15:12.
- R7: When configured, board select is high exactly while the address strobe is low and address bits 23:16 equal the assigned page. Neighbouring pages are not selected.
- R8: When configured, window reads are not answered and window writes do not change the page.
- R9: The read-data enable is low whenever the address strobe is high.
- R10: A window write with the upper data strobe high is ignored.
- R11: Bus reset clears the configuration. The chain output returns high and the old page is no longer selected.
- R12: Offsets 0x0C and 0x30, and offsets not a multiple of four (such as 0x02), read as zero while the enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, about 7 MHz |
| bus_rst_n | input | 1 | Bus reset, active low |
| bus_addr | input | 23 | Address bits 23:1 |
| bus_wdata | input | 16 | Write data from the bus master |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rw | input | 1 | High for read, low for write |
| bus_uds_n | input | 1 | Upper byte strobe, active low |
| bus_lds_n | input | 1 | Lower byte strobe, active low |
| chain_in_n | input | 1 | Configuration chain input, active low |
| bus_rdata | output | 16 | Read data for the window |
| bus_rdata_oe | output | 1 | Drive enable for bus_rdata |
| chain_out_n | output | 1 | Configuration chain output, active low |
| board_sel | output | 1 | Access to the assigned page |

## Verification
The hardest state to reach from the ports is CF_PARTIAL with a valid high nibble held. The card must stay invisible on its future page and keep answering identification reads. The stimulus writes only offset 0x48 and then probes both the window and the target page. It then sends a final-nibble write with the upper strobe held high before sending the real one, so the completion path is exercised both with and without the lane qualifier. A mid-run bus reset followed by reconfiguration to a different page shows that the committed page is not sticky across resets.

// File: rtl/acr_pkg.sv
package acr_pkg;
    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_ADDR = 2'd1,
        BS_DATA = 2'd2
    } bus_st_e;

    typedef enum logic [1:0] {
        CF_UNCONF  = 2'd0,
        CF_PARTIAL = 2'd1,
        CF_CONF    = 2'd2
    } cfg_st_e;

    localparam int NIB_W = 4;
endpackage

// File: rtl/acr_bus_fsm.sv
module acr_bus_fsm
    import acr_pkg::*;
#(
    parameter int ADDR_HI = 23,
    parameter int DATA_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_HI:1]    as_addr,
    input  logic [DATA_W-1:0]   as_wdata,
    input  logic                as_n,
    input  logic                rw,
    input  logic                uds_n,
    input  logic                lds_n,
    output logic                wr_done,
    output logic [ADDR_HI:1]    wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                wr_upper
);
    bus_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: if (!as_n && !rw) state_d = BS_ADDR;
            BS_ADDR: begin
                if (as_n)                     state_d = BS_IDLE;
                else if (!uds_n || !lds_n)    state_d = BS_DATA;
            end
            BS_DATA: if (as_n) state_d = BS_IDLE;
            default: state_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_done  <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_upper <= 1'b0;
        end else begin
            wr_done <= (state_q == BS_DATA) && as_n;
            if (state_q == BS_IDLE && state_d == BS_ADDR) begin
                wr_addr  <= as_addr;
                wr_upper <= 1'b0;
            end
            if (state_q == BS_ADDR && state_d == BS_DATA) begin
                wr_data  <= as_wdata;
                wr_upper <= !uds_n;
            end
        end
    end

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);
endmodule

// File: rtl/acr_cfg_ctrl.sv
module acr_cfg_ctrl
    import acr_pkg::*;
#(
    parameter int          ADDR_HI    = 23,
    parameter int          DATA_W     = 16,
    parameter int          PAGE_SHIFT = 16,
    parameter logic [7:0]  CFG_PAGE   = 8'hE8,
    parameter logic [7:0]  OFF_HI_NIB = 8'h48,
    parameter logic [7:0]  OFF_LO_NIB = 8'h4A,
    localparam int         PAGE_W     = ADDR_HI + 1 - PAGE_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chain_sel,
    input  logic                wr_done,
    input  logic [ADDR_HI:1]    wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                wr_upper,
    output logic                configured,
    output logic [PAGE_W-1:0]   base_page
);
    localparam int PEND_W = PAGE_W - NIB_W;

    cfg_st_e           state_q, state_d;
    logic [PEND_W-1:0] pend_q;
    logic [7:0]        wr_off;
    logic              win_wr, hi_wr, lo_wr;
    logic [NIB_W-1:0]  nib;

    assign wr_off = {wr_addr[7:1], 1'b0};
    assign nib    = wr_data[DATA_W-1 -: NIB_W];
    assign win_wr = wr_done && wr_upper && chain_sel &&
                    (wr_addr[ADDR_HI:PAGE_SHIFT] == CFG_PAGE[PAGE_W-1:0]) &&
                    (wr_addr[PAGE_SHIFT-1:8] == '0);
    assign hi_wr  = win_wr && (wr_off == OFF_HI_NIB);
    assign lo_wr  = win_wr && (wr_off == OFF_LO_NIB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CF_UNCONF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CF_UNCONF: begin
                if (lo_wr)      state_d = CF_CONF;
                else if (hi_wr) state_d = CF_PARTIAL;
            end
            CF_PARTIAL: if (lo_wr) state_d = CF_CONF;
            CF_CONF:    state_d = CF_CONF;
            default:    state_d = CF_UNCONF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            base_page <= '0;
        end else if (state_q != CF_CONF) begin
            if (hi_wr) pend_q <= nib[PEND_W-1:0];
            if (lo_wr) base_page <= {pend_q, nib};
        end
    end

    assign configured = (state_q == CF_CONF);

    p_conf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> configured);
    p_page_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> $stable(base_page));
    p_commit_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured) |-> $past(chain_sel));
    p_commit_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured) |-> $past(wr_upper));
endmodule

// File: rtl/acr_id_rom.sv
module acr_id_rom
    import acr_pkg::*;
#(
    parameter int                   ENTRIES = 12,
    parameter int                   RSV_IDX = 3,
    parameter int                   DATA_W  = 16,
    parameter logic [ENTRIES*4-1:0] ID_NIBBLES = '0
) (
    input  logic [7:0]        offset,
    output logic [DATA_W-1:0] rd_word
);
    logic [NIB_W-1:0] table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        if (g == RSV_IDX) begin : g_rsv
            assign table_q[g] = '0;
        end else begin : g_val
            assign table_q[g] = ID_NIBBLES[g*NIB_W +: NIB_W];
        end
    end

    logic [5:0] idx;
    assign idx = offset[7:2];

    always_comb begin
        rd_word = '0;
        if (offset[1:0] == 2'b00 && int'(idx) < ENTRIES)
            rd_word = {table_q[idx[$clog2(ENTRIES)-1:0]], {(DATA_W-NIB_W){1'b0}}};
    end
endmodule

// File: rtl/autocfg_responder.sv
module autocfg_responder
    import acr_pkg::*;
#(
    parameter int          ADDR_HI    = 23,
    parameter int          DATA_W     = 16,
    parameter int          PAGE_SHIFT = 16,
    parameter logic [7:0]  CFG_PAGE   = 8'hE8,
    parameter int          ID_ENTRIES = 12,
    parameter logic [47:0] ID_NIBBLES = 48'h5A3C_9604_E21F
) (
    input  logic                clk,
    input  logic                bus_rst_n,
    input  logic [ADDR_HI:1]    bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_as_n,
    input  logic                bus_rw,
    input  logic                bus_uds_n,
    input  logic                bus_lds_n,
    input  logic                chain_in_n,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rdata_oe,
    output logic                chain_out_n,
    output logic                board_sel
);
    localparam int PAGE_W = ADDR_HI + 1 - PAGE_SHIFT;

    logic                wr_done, wr_upper, configured;
    logic [ADDR_HI:1]    wr_addr;
    logic [DATA_W-1:0]   wr_data, rom_word;
    logic [PAGE_W-1:0]   base_page;
    logic                win_hit;

    acr_bus_fsm #(.ADDR_HI(ADDR_HI), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(bus_rst_n), .as_addr(bus_addr), .as_wdata(bus_wdata),
        .as_n(bus_as_n), .rw(bus_rw), .uds_n(bus_uds_n), .lds_n(bus_lds_n),
        .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data), .wr_upper(wr_upper)
    );

    acr_cfg_ctrl #(.ADDR_HI(ADDR_HI), .DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT),
                   .CFG_PAGE(CFG_PAGE)) u_cfg (
        .clk(clk), .rst_n(bus_rst_n), .chain_sel(!chain_in_n),
        .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data), .wr_upper(wr_upper),
        .configured(configured), .base_page(base_page)
    );

    acr_id_rom #(.ENTRIES(ID_ENTRIES), .DATA_W(DATA_W),
                 .ID_NIBBLES(ID_NIBBLES[ID_ENTRIES*4-1:0])) u_rom (
        .offset({bus_addr[7:1], 1'b0}), .rd_word(rom_word)
    );

    assign win_hit = (bus_addr[ADDR_HI:PAGE_SHIFT] == CFG_PAGE[PAGE_W-1:0]) &&
                     (bus_addr[PAGE_SHIFT-1:7] == '0);

    always_comb begin
        bus_rdata_oe = !bus_as_n && bus_rw && win_hit && !chain_in_n && !configured;
        bus_rdata    = bus_rdata_oe ? rom_word : '0;
        chain_out_n  = !configured;
        board_sel    = configured && !bus_as_n &&
                       (bus_addr[ADDR_HI:PAGE_SHIFT] == base_page);
    end
endmodule

// File: tb/autocfg_responder_tb.sv
module autocfg_responder_tb;
    localparam int          CLK_PERIOD = 140;
    localparam logic [47:0] ID_VAL = 48'h5A3C_9604_E21F;
    localparam int          NVEC = 14;
    localparam logic [7:0]  VEC_OFF [NVEC] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
        8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h02};

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:1] addr;
    logic [15:0] wdata;
    logic        as_n, rw, uds_n, lds_n, chain_in_n;
    logic [15:0] rdata;
    logic        rdata_oe, chain_out_n, board_sel;
    int          total = 0, bad = 0;
    logic        finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    autocfg_responder #(.ID_NIBBLES(ID_VAL)) u_dut (
        .clk(clk), .bus_rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_as_n(as_n), .bus_rw(rw), .bus_uds_n(uds_n), .bus_lds_n(lds_n),
        .chain_in_n(chain_in_n), .bus_rdata(rdata), .bus_rdata_oe(rdata_oe),
        .chain_out_n(chain_out_n), .board_sel(board_sel)
    );

    function automatic logic [15:0] exp_id(input logic [7:0] off);
        int k = int'(off) / 4;
        if (off[1:0] != 2'b00 || k >= 12 || k == 3) return 16'h0000;
        return {ID_VAL[k*4 +: 4], 12'h000};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [23:0] a, output logic [15:0] d, output logic oe);
        @(negedge clk);
        addr = a[23:1]; rw = 1'b1; as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        @(negedge clk);
        d = rdata; oe = rdata_oe;
        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        #10;
        chk("R9 enable after strobe release", rdata_oe, 0);
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [15:0] d, input logic upper);
        @(negedge clk);
        addr = a[23:1]; rw = 1'b0; as_n = 1'b0; wdata = d;
        @(negedge clk);
        uds_n = !upper; lds_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        @(negedge clk);
        rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic probe(input logic [23:0] a, output logic sel);
        @(negedge clk);
        addr = a[23:1]; rw = 1'b1; as_n = 1'b0;
        #10 sel = board_sel;
        @(negedge clk);
        as_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic        oe, sel;
        rst_n = 1'b0; addr = '0; wdata = '0; as_n = 1'b1; rw = 1'b1;
        uds_n = 1'b1; lds_n = 1'b1; chain_in_n = 1'b1;
        @(negedge clk);
        chk("R1 chain out in reset", chain_out_n, 1);
        chk("R1 select in reset", board_sel, 0);
        chk("R1 enable in reset", rdata_oe, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 chain out after reset", chain_out_n, 1);

        // R3: not selected by the chain
        bus_read(24'hE80000, d, oe);
        chk("R3 enable with chain high", oe, 0);
        // R4: writes while chain high
        bus_write(24'hE80048, 16'h9000, 1'b1);
        bus_write(24'hE8004A, 16'h1000, 1'b1);
        chk("R4 chain out stays high", chain_out_n, 1);
        probe(24'h910000, sel);
        chk("R4 page not claimed", sel, 0);

        chain_in_n = 1'b0;
        // R2, R12: identification table walk
        for (int i = 0; i < NVEC; i++) begin
            bus_read({16'hE800, VEC_OFF[i]}, d, oe);
            chk("R2 enable on window read", oe, 1);
            chk((VEC_OFF[i] == 8'h0C || VEC_OFF[i] >= 8'h30 || VEC_OFF[i] == 8'h02)
                ? "R12 zero offset" : "R2 id nibble", d, exp_id(VEC_OFF[i]));
        end

        // R5: high nibble only
        bus_write(24'hE80044, 16'h0000, 1'b1);
        bus_write(24'hE80046, 16'h0000, 1'b1);
        bus_write(24'hE80048, 16'h9000, 1'b1);
        chk("R5 chain out after partial", chain_out_n, 1);
        bus_read(24'hE80004, d, oe);
        chk("R5 id still answered", d, exp_id(8'h04));
        probe(24'h910000, sel);
        chk("R5 page not yet claimed", sel, 0);
        // R10: final nibble without upper strobe
        bus_write(24'hE8004A, 16'h1000, 1'b0);
        chk("R10 no commit without upper lane", chain_out_n, 1);
        // R6: real commit
        bus_write(24'hE8004A, 16'h1000, 1'b1);
        chk("R6 chain out low", chain_out_n, 0);

        // R7: page decode
        probe(24'h910000, sel);
        chk("R7 own page", sel, 1);
        probe(24'h91FFFE, sel);
        chk("R7 own page top", sel, 1);
        probe(24'h800000, sel);
        chk("R7 page 80", sel, 0);
        probe(24'h920000, sel);
        chk("R7 page 92", sel, 0);
        @(negedge clk);
        addr = 24'h910000 >> 1; as_n = 1'b1;
        #10 chk("R7 no strobe", board_sel, 0);

        // R8: window dead after configuration
        bus_read(24'hE80000, d, oe);
        chk("R8 no id after config", oe, 0);
        bus_write(24'hE80048, 16'h7000, 1'b1);
        bus_write(24'hE8004A, 16'h7000, 1'b1);
        probe(24'h910000, sel);
        chk("R8 page unchanged", sel, 1);
        probe(24'h770000, sel);
        chk("R8 new page ignored", sel, 0);

        // R11: bus reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R11 chain out high", chain_out_n, 1);
        probe(24'h910000, sel);
        chk("R11 old page dropped", sel, 0);
        // R6: second page pattern
        bus_write(24'hE80048, 16'hA000, 1'b1);
        bus_write(24'hE8004A, 16'h3000, 1'b1);
        chk("R6 second config", chain_out_n, 0);
        probe(24'hA30000, sel);
        chk("R6 page A3", sel, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule